// File: doc/BRIEF.md
# Two-Player Dice Game Turn Controller

This block runs a two-player "pig" style dice game from four level inputs: a roll button, a hold button, a new-game request and a synchronous reset. It contains a die counter that spins through the faces 1 to 6 while roll is held. It also contains a running turn subtotal, one saturating score register per player, a flag for which player opens the game and a flag for whose turn it is. The die stops where it is when roll is released.

A face other than 1 is added to the turn subtotal. A 1 throws the subtotal away and hands the turn over. After a good roll the player either rolls again or presses hold. Hold banks the subtotal into that player's score. A banked score at or above the winning mark ends the game, and the winner's lamp then blinks until a new game is requested. Each new game swaps which player opens.

Top module: `dice_turn_ctrl`

## Requirements
- R1: While `rst` is high the outputs show die 1, a zero subtotal, zero scores, `lamp_a` lit and `lamp_b` dark. The first game after reset is opened by player A. Player A is current-player value 0 and player B is value 1.
- R2: `die_val` holds only the values 1 to 6. On each clock with `roll` high, while the game waits to start a turn, is rolling, or waits after a good roll, it steps by one and wraps from 6 to 1. In every other case it holds.
- R3: One clock after `roll` falls, the stopped face is added to `turn_sum` if it is not 1. `turn_sum` is cleared on the clock that starts a new turn.
- R4: If the stopped face is 1, the turn passes to the other player. The subtotal is not added to either score.
- R5: After a good roll, `hold` with `roll` low adds `turn_sum` to the current player's score. `hold` has no effect while `roll` is high or while the die is rolling. Scores never decrease except when a new game or reset clears them.
- R6: A banked score below `WIN_SCORE` (default 100) passes the turn on the clock after the add.
- R7: A banked score at or above `WIN_SCORE` enters the win state on the clock after the add. While in that state:
  - the winner's lamp is lit for 2^(BLINK_W-1) clocks and then dark for the same span, repeating, starting lit;
  - the other lamp is dark;
  - `roll` and `hold` are ignored.
- R8: Every add saturates at 2^SCORE_W-1 (127 by default) instead of wrapping.
- R9: `new_game` in the win state leaves it. The next clock clears both scores, loads die 1 and gives the opening turn to the player who did not open the previous game.
- R10: Outside the win state exactly one lamp is lit. `lamp_a` is lit when player A is current and `lamp_b` when player B is current.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; forces initialisation |
| roll | input | 1 | Roll button level; die spins while high |
| hold | input | 1 | Hold button level; banks the subtotal |
| new_game | input | 1 | Leave the win state and start the next game |
| die_val | output | DIE_W | Current die face |
| turn_sum | output | SCORE_W | Subtotal of the current turn |
| score_a | output | SCORE_W | Banked score of player A |
| score_b | output | SCORE_W | Banked score of player B |
| lamp_a | output | 1 | Player A indicator (turn or blinking winner) |
| lamp_b | output | 1 | Player B indicator (turn or blinking winner) |

## Verification
Most internal faults reach the ports within one or two clocks. A wrong current-player flag moves the lit lamp at once, and a bad die step shows on `die_val` on the next edge. A skipped state appears as a subtotal or score that updates one clock early or late. A wrong opening-player flag stays hidden for a whole game and shows only at the initialisation after `new_game` or reset. The bench therefore checks the lamps right after both of those events. A wrong saturation or win threshold shows only after many rolls, so one turn is driven well past the score limit.

// File: rtl/dice_pkg.sv
package dice_pkg;
   typedef enum logic [2:0] {
      ST_INIT,
      ST_BEGIN,
      ST_ROLL,
      ST_ADD,
      ST_WAIT,
      ST_TEST,
      ST_WIN
   } game_state_t;
endpackage

// File: rtl/dice_die_counter.sv
module dice_die_counter #(
   parameter int DIE_W   = 3,
   parameter int DIE_MAX = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_one,
   input  logic             advance,
   output logic [DIE_W-1:0] face
);
   localparam logic [DIE_W-1:0] FACE_ONE = DIE_W'(1);
   localparam logic [DIE_W-1:0] FACE_TOP = DIE_W'(DIE_MAX);

   always_ff @(posedge clk) begin
      if (rst || load_one)
         face <= FACE_ONE;
      else if (advance)
         face <= (face == FACE_TOP) ? FACE_ONE : face + FACE_ONE;
   end
endmodule

// File: rtl/dice_sat_add.sv
module dice_sat_add #(
   parameter int W        = 7,
   parameter bit SATURATE = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);
   logic [W:0] wide;
   assign wide = {1'b0, a} + {1'b0, b};

   generate
      if (SATURATE) begin : g_sat
         assign sum = wide[W] ? {W{1'b1}} : wide[W-1:0];
      end else begin : g_wrap
         assign sum = wide[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/dice_blinker.sv
module dice_blinker #(
   parameter int DIV_W = 24
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic lit
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst || !run)
         cnt <= '0;
      else
         cnt <= cnt + DIV_W'(1);
   end

   assign lit = ~cnt[DIV_W-1];
endmodule

// File: rtl/dice_turn_ctrl.sv
module dice_turn_ctrl
   import dice_pkg::*;
#(
   parameter int SCORE_W   = 7,
   parameter int WIN_SCORE = 100,
   parameter int DIE_W     = 3,
   parameter int DIE_MAX   = 6,
   parameter int BLINK_W   = 24,
   parameter bit SATURATE  = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               roll,
   input  logic               hold,
   input  logic               new_game,
   output logic [DIE_W-1:0]   die_val,
   output logic [SCORE_W-1:0] turn_sum,
   output logic [SCORE_W-1:0] score_a,
   output logic [SCORE_W-1:0] score_b,
   output logic               lamp_a,
   output logic               lamp_b
);
   localparam int PLAYERS = 2;
   localparam int PAD_W   = SCORE_W - DIE_W;

   if (WIN_SCORE >= (1 << SCORE_W) || WIN_SCORE < 1) begin : g_bad_win
      $error("dice_turn_ctrl: WIN_SCORE must fit in SCORE_W bits");
   end
   if (DIE_MAX < 2 || DIE_MAX >= (1 << DIE_W)) begin : g_bad_die
      $error("dice_turn_ctrl: DIE_MAX must lie in 2..2**DIE_W-1");
   end
   if (PAD_W < 1) begin : g_bad_pad
      $error("dice_turn_ctrl: SCORE_W must exceed DIE_W");
   end
   if (BLINK_W < 1) begin : g_bad_blink
      $error("dice_turn_ctrl: BLINK_W must be at least 1");
   end

   game_state_t        state_q, state_d;
   logic               first_q, cur_q;
   logic [SCORE_W-1:0] turn_q, turn_add, score_add, active_score;
   logic [SCORE_W-1:0] score_q [PLAYERS];
   logic               die_adv, die_one, win_hit, bank, blink_lit, in_win;

   assign die_adv = roll && (state_q == ST_BEGIN || state_q == ST_ROLL || state_q == ST_WAIT);
   assign die_one = (die_val == DIE_W'(1));
   assign bank    = (state_q == ST_WAIT) && !roll && hold;
   assign in_win  = (state_q == ST_WIN);

   dice_die_counter #(.DIE_W(DIE_W), .DIE_MAX(DIE_MAX)) i_die (
      .clk(clk), .rst(rst), .load_one(state_q == ST_INIT), .advance(die_adv), .face(die_val)
   );

   dice_sat_add #(.W(SCORE_W), .SATURATE(SATURATE)) i_turn_add (
      .a(turn_q), .b({{PAD_W{1'b0}}, die_val}), .sum(turn_add)
   );

   assign active_score = score_q[cur_q];
   assign win_hit      = (active_score >= SCORE_W'(WIN_SCORE));

   dice_sat_add #(.W(SCORE_W), .SATURATE(SATURATE)) i_score_add (
      .a(active_score), .b(turn_q), .sum(score_add)
   );

   dice_blinker #(.DIV_W(BLINK_W)) i_blink (
      .clk(clk), .rst(rst), .run(in_win), .lit(blink_lit)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_INIT:  state_d = ST_BEGIN;
         ST_BEGIN: if (roll) state_d = ST_ROLL;
         ST_ROLL:  if (!roll) state_d = ST_ADD;
         ST_ADD:   state_d = die_one ? ST_BEGIN : ST_WAIT;
         ST_WAIT:  if (roll) state_d = ST_ROLL;
                   else if (hold) state_d = ST_TEST;
         ST_TEST:  state_d = win_hit ? ST_WIN : ST_BEGIN;
         ST_WIN:   if (new_game) state_d = ST_INIT;
         default:  state_d = ST_INIT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_INIT;
         first_q <= 1'b0;
         cur_q   <= 1'b0;
         turn_q  <= '0;
      end else begin
         state_q <= state_d;
         case (state_q)
            ST_INIT: begin
               cur_q  <= first_q;
               turn_q <= '0;
            end
            ST_BEGIN: turn_q <= '0;
            ST_ADD: begin
               if (die_one) cur_q  <= ~cur_q;
               else         turn_q <= turn_add;
            end
            ST_TEST: if (!win_hit) cur_q <= ~cur_q;
            ST_WIN:  if (new_game) first_q <= ~first_q;
            default: ;
         endcase
      end
   end

   for (genvar p = 0; p < PLAYERS; p++) begin : g_score
      always_ff @(posedge clk) begin
         if (rst || state_q == ST_INIT)
            score_q[p] <= '0;
         else if (bank && (cur_q == 1'(p)))
            score_q[p] <= score_add;
      end
   end

   assign turn_sum = turn_q;
   assign score_a  = score_q[0];
   assign score_b  = score_q[1];
   assign lamp_a   = (cur_q == 1'b0) && (!in_win || blink_lit);
   assign lamp_b   = (cur_q == 1'b1) && (!in_win || blink_lit);
endmodule

// File: rtl/dice_turn_ctrl_chk.sv
module dice_turn_ctrl_chk
   import dice_pkg::*;
#(
   parameter int SCORE_W   = 7,
   parameter int WIN_SCORE = 100,
   parameter int DIE_W     = 3,
   parameter int DIE_MAX   = 6
) (
   input logic               clk,
   input logic               rst,
   input logic               new_game,
   input logic [DIE_W-1:0]   die_val,
   input logic [SCORE_W-1:0] score_a,
   input logic [SCORE_W-1:0] score_b,
   input logic               lamp_a,
   input logic               lamp_b,
   input game_state_t        state_q,
   input logic               cur_q
);
   assert_die_range_R2: assert property (@(posedge clk) disable iff (rst)
      (die_val >= DIE_W'(1)) && (die_val <= DIE_W'(DIE_MAX)));

   assert_die_step_R2: assert property (@(posedge clk) disable iff (rst)
      (state_q != ST_INIT) |=>
         (die_val == $past(die_val)) ||
         (die_val == (($past(die_val) == DIE_W'(DIE_MAX)) ? DIE_W'(1) : $past(die_val) + DIE_W'(1))));

   assert_one_lamp_R10: assert property (@(posedge clk) disable iff (rst)
      (state_q != ST_WIN) |-> (lamp_a != lamp_b));

   assert_score_keeps_R5: assert property (@(posedge clk) disable iff (rst)
      (state_q != ST_INIT) |=> (score_a >= $past(score_a)) && (score_b >= $past(score_b)));

   assert_win_score_R7: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_WIN) |-> ((cur_q ? score_b : score_a) >= SCORE_W'(WIN_SCORE)));

   assert_win_stays_R9: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_WIN && !new_game) |=> (state_q == ST_WIN));
endmodule

bind dice_turn_ctrl dice_turn_ctrl_chk #(
   .SCORE_W(SCORE_W), .WIN_SCORE(WIN_SCORE), .DIE_W(DIE_W), .DIE_MAX(DIE_MAX)
) i_chk (
   .clk(clk), .rst(rst), .new_game(new_game), .die_val(die_val),
   .score_a(score_a), .score_b(score_b), .lamp_a(lamp_a), .lamp_b(lamp_b),
   .state_q(state_q), .cur_q(cur_q)
);

// File: tb/test_dice_turn_ctrl.sv
`timescale 1ns/1ps
module test_dice_turn_ctrl;
   localparam int BLINK_W = 3;
   localparam int HALF    = 1 << (BLINK_W - 1);

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic roll = 1'b0, hold = 1'b0, new_game = 1'b0;
   logic [2:0] die_val;
   logic [6:0] turn_sum, score_a, score_b;
   logic lamp_a, lamp_b;

   int checks = 0;
   int failures = 0;
   int ref_die = 1;
   int exp_ts = 0;

   always #2.5 clk = ~clk;

   dice_turn_ctrl #(.BLINK_W(BLINK_W)) i_dice_turn_ctrl (
      .clk(clk), .rst(rst), .roll(roll), .hold(hold), .new_game(new_game),
      .die_val(die_val), .turn_sum(turn_sum), .score_a(score_a), .score_b(score_b),
      .lamp_a(lamp_a), .lamp_b(lamp_b)
   );

   typedef struct packed {
      logic       r, h, n;
      logic [2:0] die;
      logic [6:0] ts, sa, sb;
      logic       la, lb;
      logic [3:0] req;
   } vec_t;

   function automatic vec_t mk(input logic r, h, n, input int d, t, a, b, input logic la, lb,
                               input int q);
      vec_t v;
      v.r = r; v.h = h; v.n = n;
      v.die = 3'(d); v.ts = 7'(t); v.sa = 7'(a); v.sb = 7'(b);
      v.la = la; v.lb = lb; v.req = 4'(q);
      return v;
   endfunction

   // roll hold new | die sub A B lampA lampB | requirement
   localparam vec_t VECS [0:23] = '{
      mk(0,0,0, 1,0,0,0, 1,0, 1),   // R1 player A opens
      mk(1,0,0, 2,0,0,0, 1,0, 2),   // R2
      mk(1,0,0, 3,0,0,0, 1,0, 2),   // R2
      mk(0,0,0, 3,0,0,0, 1,0, 2),   // R2 stops
      mk(0,0,0, 3,3,0,0, 1,0, 3),   // R3 add face
      mk(0,1,0, 3,3,3,0, 1,0, 5),   // R5 bank
      mk(0,0,0, 3,3,3,0, 0,1, 6),   // R6 pass
      mk(1,0,0, 4,0,3,0, 0,1, 3),   // R3 cleared
      mk(0,0,0, 4,0,3,0, 0,1, 2),   // R2
      mk(0,0,0, 4,4,3,0, 0,1, 3),   // R3
      mk(1,0,0, 5,4,3,0, 0,1, 2),   // R2
      mk(1,0,0, 6,4,3,0, 0,1, 2),   // R2
      mk(1,0,0, 1,4,3,0, 0,1, 2),   // R2 wrap
      mk(0,0,0, 1,4,3,0, 0,1, 2),   // R2
      mk(0,0,0, 1,4,3,0, 1,0, 4),   // R4 lose turn
      mk(0,0,0, 1,0,3,0, 1,0, 4),   // R4 nothing banked
      mk(1,0,0, 2,0,3,0, 1,0, 2),   // R2
      mk(0,0,0, 2,0,3,0, 1,0, 2),   // R2
      mk(0,0,0, 2,2,3,0, 1,0, 3),   // R3
      mk(1,1,0, 3,2,3,0, 1,0, 5),   // R5 hold ignored under roll
      mk(0,1,0, 3,2,3,0, 1,0, 5),   // R5 hold ignored while rolling
      mk(0,1,0, 3,5,3,0, 1,0, 3),   // R3
      mk(0,1,0, 3,5,8,0, 1,0, 5),   // R5
      mk(0,0,0, 3,5,8,0, 0,1, 10)   // R10
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cyc(input logic r, input logic h, input logic n);
      roll = r; hold = h; new_game = n;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic roll_to_six();
      int n;
      n = (ref_die == 6) ? 6 : 6 - ref_die;
      for (int i = 0; i < n; i++) cyc(1, 0, 0);
      ref_die = 6;
      cyc(0, 0, 0);
      cyc(0, 0, 0);
      exp_ts = (exp_ts + 6 > 127) ? 127 : exp_ts + 6;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "reset die", die_val, 1);
      chk("R1", "reset sub", turn_sum, 0);
      chk("R1", "reset A", score_a, 0);
      chk("R1", "reset B", score_b, 0);
      chk("R1", "reset lampA", lamp_a, 1);
      chk("R1", "reset lampB", lamp_b, 0);
      rst = 1'b0;

      for (int k = 0; k < 24; k++) begin
         string tag;
         tag = $sformatf("R%0d row%0d", VECS[k].req, k);
         cyc(VECS[k].r, VECS[k].h, VECS[k].n);
         chk(tag, "die", die_val, VECS[k].die);
         chk(tag, "sub", turn_sum, VECS[k].ts);
         chk(tag, "A", score_a, VECS[k].sa);
         chk(tag, "B", score_b, VECS[k].sb);
         chk(tag, "lampA", lamp_a, VECS[k].la);
         chk(tag, "lampB", lamp_b, VECS[k].lb);
      end

      // Player B rolls sixes until the subtotal saturates
      ref_die = 3;
      exp_ts = 0;
      for (int i = 0; i < 16; i++) roll_to_six();
      chk("R3", "sub after 16 sixes", turn_sum, 96);
      for (int i = 0; i < 6; i++) roll_to_six();
      chk("R8", "sub saturated", turn_sum, 127);
      chk("R8", "bench model", exp_ts, 127);
      cyc(0, 1, 0);
      chk("R5", "B banked", score_b, 127);
      chk("R5", "A untouched", score_a, 8);
      cyc(0, 0, 0);
      chk("R7", "winner lit on entry", lamp_b, 1);
      chk("R7", "loser dark", lamp_a, 0);
      for (int i = 0; i < HALF; i++) cyc(1, 1, 0);
      chk("R7", "winner dark half period", lamp_b, 0);
      chk("R7", "die frozen in win", die_val, 6);
      chk("R7", "score frozen in win", score_b, 127);
      for (int i = 0; i < HALF; i++) cyc(0, 0, 0);
      chk("R7", "winner lit again", lamp_b, 1);
      chk("R7", "loser still dark", lamp_a, 0);

      cyc(0, 0, 1);
      cyc(0, 0, 0);
      chk("R9", "A cleared", score_a, 0);
      chk("R9", "B cleared", score_b, 0);
      chk("R9", "die reloaded", die_val, 1);
      chk("R9", "B opens lampB", lamp_b, 1);
      chk("R9", "B opens lampA", lamp_a, 0);
      cyc(0, 0, 0);
      chk("R10", "lamp follows B", lamp_b, 1);

      cyc(1, 0, 0);
      cyc(1, 0, 0);
      chk("R2", "die spins again", die_val, 3);
      rst = 1'b1;
      cyc(1, 0, 0);
      chk("R1", "mid-game reset die", die_val, 1);
      chk("R1", "mid-game reset lampA", lamp_a, 1);
      rst = 1'b0;
      cyc(0, 0, 0);
      chk("R1", "A opens after reset", lamp_a, 1);
      chk("R1", "B dark after reset", lamp_b, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule